// File: doc/BRIEF.md
# Two-Level Masked Interrupt Arbiter

This block sits between a set of peripheral interrupt request lines and a CPU core and decides, every clock, which single request (if any) the core should be shown. Each maskable source carries its own enable bit and a one-bit priority level (low or high). A configuration bit selects the masking scheme. In single-mask mode, one CPU mask bit blocks every maskable source. In split-mask mode, a second CPU mask bit lets high-level sources through while low-level sources stay blocked.

A separate non-maskable request is captured on its rising edge. It stays pending until the core pulses the acknowledge input. It always beats the maskable sources and is reported with its own index code, one above the highest maskable index. The decision is registered, so the outputs follow the inputs with one clock of latency. A standby input, like reset, forces the outputs inactive and discards a pending non-maskable request.

Top module: `irq_two_level_arb`

## Requirements
- R1: While and after `rst_n` is low, `out_valid`, `out_idx` and `out_lvl` are all 0. They read 0 whenever no request is presented.
- R2: With `mode_single`=1 and `mask_all`=0, every enabled, asserted maskable source can be presented.
- R3: With `mode_single`=1 and `mask_all`=1, no maskable source is presented, whatever the value of `mask_low`.
- R4: With `mode_single`=0 and `mask_all`=0, every enabled, asserted maskable source can be presented, whatever the value of `mask_low`.
- R5: With `mode_single`=0, `mask_all`=1 and `mask_low`=0, only sources whose `src_lvl` bit is 1 (high level) can be presented.
- R6: With `mode_single`=0, `mask_all`=1 and `mask_low`=1, no maskable source is presented.
- R7: A source whose `src_en` bit is 0 is never presented, even while its request is asserted.
- R8: If any accepted high-level source is pending, a high-level source wins over every low-level source. `out_lvl` reports 1 for high level and 0 for low level.
- R9: Among accepted sources of the same level, the lowest index wins.
- R10: A pending non-maskable request wins over all maskable sources, regardless of the mask bits. It is reported with `out_idx` = N_SRC (8 by default) and `out_lvl` = 1.
- R11: The non-maskable request is latched on a rising edge of `nmi_in` and stays presented until `ack` is high on a clock edge. Holding `nmi_in` high does not re-arm it; only a new rising edge does.
- R12: The outputs change on the first rising clock edge after an input change, and not before.
- R13: While `standby` is high, the outputs are 0 on the following edges. A pending non-maskable request is discarded and does not reappear after `standby` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby: forces outputs inactive, clears the non-maskable latch |
| src_req | input | N_SRC | Level-sensitive maskable requests |
| src_en | input | N_SRC | Per-source enable |
| src_lvl | input | N_SRC | Per-source priority level (1 = high) |
| mode_single | input | 1 | 1 = single-mask scheme, 0 = split-mask scheme |
| mask_all | input | 1 | CPU primary mask bit |
| mask_low | input | 1 | CPU secondary mask bit (split-mask scheme only) |
| nmi_in | input | 1 | Non-maskable request, edge-sensitive |
| ack | input | 1 | Acknowledge: clears the latched non-maskable request |
| out_valid | output | 1 | A request is presented |
| out_idx | output | IDX_W | Winning index; N_SRC denotes the non-maskable request |
| out_lvl | output | 1 | Level of the winner |

## Verification
The bench goes after the mask combinations that differ between the two schemes. If a design honoured `mask_low` in single-mask mode, it would present high-level sources that must stay blocked. If it ignored `mask_low` in split-mask mode, it would block everything or nothing where only the high level should pass. Ordering cases pit a higher-numbered high-level source against a lower-numbered low-level one, which exposes an arbiter that sorts by index alone. The non-maskable path is checked under full masking, with `nmi_in` held high across an acknowledge (a level-sensitive latch would re-present it), and across standby (a latch that survived would reappear when standby falls).

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } prio_lvl_e;

    // Returns {pass_high, pass_low} for the current mask configuration.
    function automatic logic [1:0] lvl_pass(
        input logic single_mask,
        input logic mask_all,
        input logic mask_low
    );
        logic pass_low;
        logic pass_high;
        pass_low  = !mask_all;
        pass_high = !mask_all || (!single_mask && !mask_low);
        return {pass_high, pass_low};
    endfunction

endpackage

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] src_lvl,
    input  logic             mode_single,
    input  logic             mask_all,
    input  logic             mask_low,
    output logic [N_SRC-1:0] acc_high,
    output logic [N_SRC-1:0] acc_low
);

    logic [1:0] pass_w;

    assign pass_w = lvl_pass(mode_single, mask_all, mask_low);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic live_w;
        assign live_w      = src_req[g] & src_en[g];
        assign acc_high[g] = live_w &  src_lvl[g] & pass_w[1];
        assign acc_low[g]  = live_w & ~src_lvl[g] & pass_w[0];
    end

endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
    parameter int N_SRC = 8,
    parameter int IDX_W = 4
) (
    input  logic [N_SRC-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (vec[k]) begin
                found = 1'b1;
                idx   = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/irq_two_level_arb.sv
module irq_two_level_arb
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] src_lvl,
    input  logic             mode_single,
    input  logic             mask_all,
    input  logic             mask_low,
    input  logic             nmi_in,
    input  logic             ack,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic             out_lvl
);

    localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(N_SRC);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        prio_lvl_e        lvl;
        logic             nmi_pend;
        logic             nmi_prev;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [N_SRC-1:0] acc_high_w, acc_low_w;
    logic             hi_found_w, lo_found_w;
    logic [IDX_W-1:0] hi_idx_w, lo_idx_w;
    logic             nmi_rise_w;

    irq_mask_gate #(.N_SRC(N_SRC)) gate_i (
        .src_req    (src_req),
        .src_en     (src_en),
        .src_lvl    (src_lvl),
        .mode_single(mode_single),
        .mask_all   (mask_all),
        .mask_low   (mask_low),
        .acc_high   (acc_high_w),
        .acc_low    (acc_low_w)
    );

    irq_low_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) pick_high_i (
        .vec  (acc_high_w),
        .found(hi_found_w),
        .idx  (hi_idx_w)
    );

    irq_low_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) pick_low_i (
        .vec  (acc_low_w),
        .found(lo_found_w),
        .idx  (lo_idx_w)
    );

    assign nmi_rise_w = nmi_in & ~state_q.nmi_prev;

    always_comb begin
        state_d          = state_q;
        state_d.nmi_prev = nmi_in;
        state_d.nmi_pend = (state_q.nmi_pend & ~ack) | nmi_rise_w;

        if (state_d.nmi_pend) begin
            state_d.valid = 1'b1;
            state_d.idx   = NMI_IDX;
            state_d.lvl   = LVL_HIGH;
        end else if (hi_found_w) begin
            state_d.valid = 1'b1;
            state_d.idx   = hi_idx_w;
            state_d.lvl   = LVL_HIGH;
        end else if (lo_found_w) begin
            state_d.valid = 1'b1;
            state_d.idx   = lo_idx_w;
            state_d.lvl   = LVL_LOW;
        end else begin
            state_d.valid = 1'b0;
            state_d.idx   = '0;
            state_d.lvl   = LVL_LOW;
        end

        if (standby) begin
            state_d.valid    = 1'b0;
            state_d.idx      = '0;
            state_d.lvl      = LVL_LOW;
            state_d.nmi_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_idx   = state_q.idx;
    assign out_lvl   = state_q.lvl;

    // R3: single-mask scheme with primary mask set lets only the NMI code through
    assert_single_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_single && mask_all) && out_valid) |-> (out_idx == NMI_IDX));

    // R6: split-mask scheme with both bits set lets only the NMI code through
    assert_split_full_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mode_single && mask_all && mask_low) && out_valid) |-> (out_idx == NMI_IDX));

    // R5: split-mask scheme, secondary bit clear: any maskable winner is high level
    assert_split_high_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mode_single && mask_all && !mask_low) && out_valid && out_idx != NMI_IDX)
        |-> out_lvl);

    // R7: a maskable winner was enabled and requesting on the deciding edge
    assert_enabled_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx != NMI_IDX)
        |-> ((($past(src_en & src_req) >> out_idx) & N_SRC'(1)) != '0));

    // R10: NMI code is always reported at high level
    assert_nmi_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx == NMI_IDX) |-> out_lvl);

    // R13: standby clears the outputs on the next edge
    assert_standby_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(standby) |-> (!out_valid && out_idx == '0 && !out_lvl));

endmodule

// File: tb/irq_two_level_arb_tb_top.sv
module irq_two_level_arb_tb_top;

    localparam int N_SRC = 8;
    localparam int IDX_W = $clog2(N_SRC + 1);
    localparam logic [IDX_W-1:0] NMI_CODE = IDX_W'(N_SRC);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             standby = 1'b0;
    logic [N_SRC-1:0] src_req = '0;
    logic [N_SRC-1:0] src_en = '0;
    logic [N_SRC-1:0] src_lvl = '0;
    logic             mode_single = 1'b0;
    logic             mask_all = 1'b0;
    logic             mask_low = 1'b0;
    logic             nmi_in = 1'b0;
    logic             ack = 1'b0;
    logic             out_valid;
    logic [IDX_W-1:0] out_idx;
    logic             out_lvl;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    irq_two_level_arb #(.N_SRC(N_SRC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .src_req    (src_req),
        .src_en     (src_en),
        .src_lvl    (src_lvl),
        .mode_single(mode_single),
        .mask_all   (mask_all),
        .mask_low   (mask_low),
        .nmi_in     (nmi_in),
        .ack        (ack),
        .out_valid  (out_valid),
        .out_idx    (out_idx),
        .out_lvl    (out_lvl)
    );

    typedef struct packed {
        logic [15:0]      tag;
        logic             ue;
        logic             mi;
        logic             ml;
        logic [N_SRC-1:0] req;
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] lvl;
        logic             ev;
        logic [IDX_W-1:0] eidx;
        logic             elvl;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{"R2", 1'b1, 1'b0, 1'b0, 8'h24, 8'hFF, 8'h00, 1'b1, 4'd2, 1'b0},
        '{"R3", 1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 4'd0, 1'b0},
        '{"R4", 1'b0, 1'b0, 1'b1, 8'h80, 8'hFF, 8'h00, 1'b1, 4'd7, 1'b0},
        '{"R4", 1'b0, 1'b0, 1'b0, 8'h10, 8'hFF, 8'h00, 1'b1, 4'd4, 1'b0},
        '{"R5", 1'b0, 1'b1, 1'b0, 8'h0F, 8'hFF, 8'h08, 1'b1, 4'd3, 1'b1},
        '{"R5", 1'b0, 1'b1, 1'b0, 8'h07, 8'hFF, 8'h08, 1'b0, 4'd0, 1'b0},
        '{"R6", 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0, 4'd0, 1'b0},
        '{"R7", 1'b1, 1'b0, 1'b0, 8'h06, 8'hF9, 8'h00, 1'b0, 4'd0, 1'b0},
        '{"R7", 1'b1, 1'b0, 1'b0, 8'h06, 8'h04, 8'h00, 1'b1, 4'd2, 1'b0},
        '{"R8", 1'b1, 1'b0, 1'b0, 8'h41, 8'hFF, 8'h40, 1'b1, 4'd6, 1'b1},
        '{"R9", 1'b1, 1'b0, 1'b0, 8'h30, 8'hFF, 8'h30, 1'b1, 4'd4, 1'b1},
        '{"R9", 1'b1, 1'b0, 1'b0, 8'hC0, 8'hFF, 8'h00, 1'b1, 4'd6, 1'b0},
        '{"R3", 1'b1, 1'b1, 1'b0, 8'h81, 8'hFF, 8'hFF, 1'b0, 4'd0, 1'b0}
    };

    task automatic check(input string tag, input logic ev,
                         input logic [IDX_W-1:0] eidx, input logic elvl);
        n_checks++;
        if (out_valid !== ev || out_idx !== eidx || out_lvl !== elvl) begin
            n_errors++;
            $display("FAIL %s: got valid=%0b idx=%0d lvl=%0b, expected valid=%0b idx=%0d lvl=%0b",
                     tag, out_valid, out_idx, out_lvl, ev, eidx, elvl);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs idle while in reset
        repeat (3) @(negedge clk);
        src_req = 8'hFF; src_en = 8'hFF; mode_single = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, '0, 1'b0);
        src_req = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, '0, 1'b0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            mode_single = VECS[v].ue;
            mask_all    = VECS[v].mi;
            mask_low    = VECS[v].ml;
            src_req     = VECS[v].req;
            src_en      = VECS[v].en;
            src_lvl     = VECS[v].lvl;
            @(negedge clk);
            check($sformatf("%s", VECS[v].tag), VECS[v].ev, VECS[v].eidx, VECS[v].elvl);
        end

        // R12: output holds until the next rising edge
        mode_single = 1'b1; mask_all = 1'b0; mask_low = 1'b0;
        src_en = 8'hFF; src_lvl = 8'h00; src_req = 8'h02;
        @(negedge clk);
        check("R12", 1'b1, 4'd1, 1'b0);
        src_req = 8'h20;
        #1;
        check("R12", 1'b1, 4'd1, 1'b0);
        @(negedge clk);
        check("R12", 1'b1, 4'd5, 1'b0);

        // R10: NMI beats a high-level source under full masking
        mode_single = 1'b0; mask_all = 1'b1; mask_low = 1'b0;
        src_lvl = 8'hFF; src_req = 8'h01;
        @(negedge clk);
        check("R5", 1'b1, 4'd0, 1'b1);
        mask_low = 1'b1;
        nmi_in = 1'b1;
        @(negedge clk);
        check("R10", 1'b1, NMI_CODE, 1'b1);

        // R11: held high across ack does not re-arm
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R11", 1'b0, '0, 1'b0);
        repeat (2) @(negedge clk);
        check("R11", 1'b0, '0, 1'b0);
        nmi_in = 1'b0;
        @(negedge clk);
        nmi_in = 1'b1;
        @(negedge clk);
        check("R11", 1'b1, NMI_CODE, 1'b1);
        repeat (3) @(negedge clk);
        check("R11", 1'b1, NMI_CODE, 1'b1);

        // R13: standby drops outputs and discards the pending NMI
        mask_all = 1'b0; src_req = 8'h10;
        standby = 1'b1;
        @(negedge clk);
        check("R13", 1'b0, '0, 1'b0);
        standby = 1'b0; src_req = '0;
        @(negedge clk);
        check("R13", 1'b0, '0, 1'b0);

        finish_run();
    end

endmodule